// File: doc/BRIEF.md
# Performance Monitor Counter Bank

This block gives a processor a bank of programmable event counters plus a free-running cycle counter, all reached through a simple word-addressed register port. Each event counter is 32 bits wide and picks one line from a vector of incoming event pulses by event number. It can skip counting at privilege level 0 or level 1. The number of event counters is set by a parameter, from 1 to 31.

Software enables counters and overflow interrupts through pairs of set and clear registers. Both registers of a pair read back the same mask. A wrap from 0xFFFFFFFF to 0 sets a sticky overflow status bit, which software clears by writing 1 to it. The interrupt output is a level signal formed from the status bits that are interrupt-enabled.

A selector register picks one counter. An indirect type register and an indirect count register then alias that counter's own registers. Reads are combinational from the address, and writes take effect at the next clock edge.

Top module: `pmc_bank`

## Requirements
- R1: Addresses: control 0x00, enable-set 0x01, enable-clear 0x02, overflow status 0x03, irq-enable-set 0x04, irq-enable-clear 0x05, selector 0x06, indirect type 0x07, indirect count 0x08, cycle counter 0x09, counter k at 0x40+k, type k at 0x80+k. In the control register, bit 0 is the global count enable and bits 5:3 are plain read/write bits. Bit 6 always reads 1, bits 15:11 read the number of event counters, and all other bits read 0.
- R2: Control bits 1 and 2 always read 0. Writing 1 to bit 1 clears every event counter, and writing 1 to bit 2 clears the cycle counter, on that write's edge only. After a write of 0x46, the control register reads (N<<11)|0x40.
- R3: Bit k of the enable mask (k < N) enables event counter k, and bit 31 enables the cycle counter. Writing 1s to enable-set sets those bits and writing 1s to enable-clear clears them. Both addresses read the same mask.
- R4: Mask bits 30:N of the enable and interrupt-enable masks ignore writes and read 0.
- R5: The interrupt-enable mask uses the same set/clear pair scheme and bit layout as the enable mask.
- R6: A counter that increments from 0xFFFFFFFF to 0 sets its overflow status bit: bit k for event counter k, bit 31 for the cycle counter. Writing 1 to a status bit clears it, and a wrap in the same cycle wins.
- R7: An event counter increments on a clock edge only when all of these hold: the global enable is 1, its enable bit is 1, the pulse named by its event number is high, and the current privilege level is not excluded. Event numbers at or above the pulse vector width never count. The cycle counter counts every edge while the global enable and mask bit 31 are both 1.
- R8: A type register keeps bits 31:24 and 15:0, and bits 23:16 read 0. Bit 31 excludes privilege level 1 and bit 30 excludes level 0. The event number is bits 15:0.
- R9: When the selector holds k < N, the indirect type and indirect count registers read and write type k and counter k. When the selector holds k ≥ N, they read 0 and writes to them change nothing.
- R10: A counter accepts and returns any written value, whatever event it is set to. A register write to a counter takes priority over an increment in the same cycle.
- R11: Two counters set to the same event number count it identically.
- R12: The interrupt output is high exactly while some overflow status bit and its interrupt-enable bit are both 1.
- R13: After reset, all counters, masks, overflow status, the selector and the type registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| evt_i | input | NUM_EVT | Event pulses, indexed by event number |
| priv_i | input | 2 | Current privilege level |
| irq_o | output | 1 | Overflow interrupt, level |

## Verification
The bench builds the bank with NUM_CTR=4 and NUM_EVT=32. With 4 counters, mask bits 30:4 are unimplemented, so the ignored-write rule and the out-of-range selector values 4 to 31 can both be driven. With a 32-wide pulse vector, event numbers 32 to 39 in the random phase exercise the rule that such events never count, while the cycle, instruction and memory-access event numbers stay in range. Counters preset close to 0xFFFFFFFF bring wrap, overflow clearing and interrupt behaviour within a few tens of cycles.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int AW = 8;
   localparam int DW = 32;

   localparam logic [AW-1:0] A_CTRL     = 8'h00;
   localparam logic [AW-1:0] A_EN_SET   = 8'h01;
   localparam logic [AW-1:0] A_EN_CLR   = 8'h02;
   localparam logic [AW-1:0] A_OVF      = 8'h03;
   localparam logic [AW-1:0] A_IE_SET   = 8'h04;
   localparam logic [AW-1:0] A_IE_CLR   = 8'h05;
   localparam logic [AW-1:0] A_SEL      = 8'h06;
   localparam logic [AW-1:0] A_SEL_TYPE = 8'h07;
   localparam logic [AW-1:0] A_SEL_CNT  = 8'h08;
   localparam logic [AW-1:0] A_CYC      = 8'h09;
   localparam logic [AW-1:0] A_CNT_BASE = 8'h40;
   localparam logic [AW-1:0] A_TYP_BASE = 8'h80;

   localparam int B_RUN     = 0;
   localparam int B_CLR_EVT = 1;
   localparam int B_CLR_CYC = 2;

   localparam logic [DW-1:0] TYPE_KEEP = 32'hFF00_FFFF;
   localparam int CYC_BIT = 31;
endpackage

// File: rtl/pmc_mask_reg.sv
module pmc_mask_reg #(
   parameter int W = 32,
   parameter logic [W-1:0] IMPL = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         set_we_i,
   input  logic         clr_we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] legal;
   assign legal = wdata_i & IMPL;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       mask_o <= '0;
      else if (set_we_i) mask_o <= mask_o | legal;
      else if (clr_we_i) mask_o <= mask_o & ~legal;
   end
endmodule

// File: rtl/pmc_event_ctr.sv
module pmc_event_ctr
   import pmc_pkg::*;
#(
   parameter int NUM_EVT = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               type_we_i,
   input  logic               cnt_we_i,
   input  logic [DW-1:0]      wdata_i,
   input  logic               clr_i,
   input  logic               run_i,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [1:0]         priv_i,
   output logic [DW-1:0]      type_o,
   output logic [DW-1:0]      cnt_o,
   output logic               wrap_o
);
   localparam int EW = $clog2(NUM_EVT);
   localparam logic [16:0] EV_LIM = 17'(NUM_EVT);

   logic [15:0] evnum;
   logic        evt_hit, excluded, inc;

   assign evnum    = type_o[15:0];
   assign evt_hit  = ({1'b0, evnum} < EV_LIM) ? evt_i[evnum[EW-1:0]] : 1'b0;
   assign excluded = (priv_i == 2'd0 && type_o[30]) || (priv_i == 2'd1 && type_o[31]);
   assign inc      = run_i && evt_hit && !excluded;
   assign wrap_o   = inc && !cnt_we_i && !clr_i && (cnt_o == '1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        type_o <= '0;
      else if (type_we_i) type_o <= wdata_i & TYPE_KEEP;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_o <= '0;
      else if (cnt_we_i) cnt_o <= wdata_i;
      else if (clr_i)    cnt_o <= '0;
      else if (inc)      cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/pmc_cycle_ctr.sv
module pmc_cycle_ctr
   import pmc_pkg::*;
(
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          we_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          clr_i,
   input  logic          run_i,
   output logic [DW-1:0] cnt_o,
   output logic          wrap_o
);
   assign wrap_o = run_i && !we_i && !clr_i && (cnt_o == '1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cnt_o <= '0;
      else if (we_i)  cnt_o <= wdata_i;
      else if (clr_i) cnt_o <= '0;
      else if (run_i) cnt_o <= cnt_o + 1'b1;
   end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
   import pmc_pkg::*;
#(
   parameter int NUM_CTR = 4,
   parameter int NUM_EVT = 32
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic [7:0]         addr_i,
   input  logic [31:0]        wdata_i,
   output logic [31:0]        rdata_o,
   input  logic [NUM_EVT-1:0] evt_i,
   input  logic [1:0]         priv_i,
   output logic               irq_o
);
   localparam logic [DW-1:0] IMPL = 32'h8000_0000 | ((32'h1 << NUM_CTR) - 32'h1);
   localparam logic [4:0]    NFIELD = 5'(NUM_CTR);

   if (NUM_CTR < 1 || NUM_CTR > 31) begin : g_bad_ctr
      $error("pmc_bank: NUM_CTR must be within 1..31");
   end
   if (NUM_EVT < 2 || NUM_EVT > 65536) begin : g_bad_evt
      $error("pmc_bank: NUM_EVT must be within 2..65536");
   end

   logic          run_q;
   logic [2:0]    spare_q;
   logic [4:0]    sel_q;
   logic [DW-1:0] en_q, ie_q, ovf_q, wrap_vec, cyc_q;
   logic          cyc_wrap;
   logic          wr_ctrl, clr_evt, clr_cyc;
   logic [DW-1:0] typ [NUM_CTR];
   logic [DW-1:0] cnt [NUM_CTR];
   logic [NUM_CTR-1:0] wrap;

   assign wr_ctrl = we_i && addr_i == A_CTRL;
   assign clr_evt = wr_ctrl && wdata_i[B_CLR_EVT];
   assign clr_cyc = wr_ctrl && wdata_i[B_CLR_CYC];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q   <= 1'b0;
         spare_q <= '0;
         sel_q   <= '0;
      end else begin
         if (wr_ctrl) begin
            run_q   <= wdata_i[B_RUN];
            spare_q <= wdata_i[5:3];
         end
         if (we_i && addr_i == A_SEL) sel_q <= wdata_i[4:0];
      end
   end

   pmc_mask_reg #(.W(DW), .IMPL(IMPL)) u_en (
      .clk_i, .rst_ni,
      .set_we_i (we_i && addr_i == A_EN_SET),
      .clr_we_i (we_i && addr_i == A_EN_CLR),
      .wdata_i,
      .mask_o   (en_q)
   );

   pmc_mask_reg #(.W(DW), .IMPL(IMPL)) u_ie (
      .clk_i, .rst_ni,
      .set_we_i (we_i && addr_i == A_IE_SET),
      .clr_we_i (we_i && addr_i == A_IE_CLR),
      .wdata_i,
      .mask_o   (ie_q)
   );

   for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
      logic hit_sel;
      assign hit_sel = (sel_q == 5'(k));
      pmc_event_ctr #(.NUM_EVT(NUM_EVT)) u_ctr (
         .clk_i, .rst_ni,
         .type_we_i (we_i && (addr_i == A_TYP_BASE + 8'(k) || (addr_i == A_SEL_TYPE && hit_sel))),
         .cnt_we_i  (we_i && (addr_i == A_CNT_BASE + 8'(k) || (addr_i == A_SEL_CNT && hit_sel))),
         .wdata_i,
         .clr_i     (clr_evt),
         .run_i     (run_q && en_q[k]),
         .evt_i,
         .priv_i,
         .type_o    (typ[k]),
         .cnt_o     (cnt[k]),
         .wrap_o    (wrap[k])
      );
   end

   pmc_cycle_ctr u_cyc (
      .clk_i, .rst_ni,
      .we_i    (we_i && addr_i == A_CYC),
      .wdata_i,
      .clr_i   (clr_cyc),
      .run_i   (run_q && en_q[CYC_BIT]),
      .cnt_o   (cyc_q),
      .wrap_o  (cyc_wrap)
   );

   always_comb begin
      wrap_vec = '0;
      wrap_vec[NUM_CTR-1:0] = wrap;
      wrap_vec[CYC_BIT] = cyc_wrap;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ovf_q <= '0;
      else if (we_i && addr_i == A_OVF) ovf_q <= (ovf_q & ~(wdata_i & IMPL)) | wrap_vec;
      else ovf_q <= ovf_q | wrap_vec;
   end

   assign irq_o = |(ovf_q & ie_q);

   always_comb begin
      rdata_o = '0;
      case (addr_i)
         A_CTRL:             rdata_o = {16'b0, NFIELD, 4'b0, 1'b1, spare_q, 2'b00, run_q};
         A_EN_SET, A_EN_CLR: rdata_o = en_q;
         A_OVF:              rdata_o = ovf_q;
         A_IE_SET, A_IE_CLR: rdata_o = ie_q;
         A_SEL:              rdata_o = {27'b0, sel_q};
         A_CYC:              rdata_o = cyc_q;
         default:            rdata_o = '0;
      endcase
      for (int k = 0; k < NUM_CTR; k++) begin
         if (addr_i == A_CNT_BASE + 8'(k)) rdata_o = cnt[k];
         if (addr_i == A_TYP_BASE + 8'(k)) rdata_o = typ[k];
         if (sel_q == 5'(k) && addr_i == A_SEL_CNT)  rdata_o = cnt[k];
         if (sel_q == 5'(k) && addr_i == A_SEL_TYPE) rdata_o = typ[k];
      end
   end
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
   import pmc_pkg::*;
#(
   parameter int NUM_CTR = 4
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        we_i,
   input logic [7:0]  addr_i,
   input logic [31:0] wdata_i,
   input logic [31:0] rdata_o,
   input logic        irq_o,
   input logic [31:0] en_q,
   input logic [31:0] ie_q,
   input logic        run_q,
   input logic [31:0] cyc_q
);
   localparam logic [31:0] IMPL = 32'h8000_0000 | ((32'h1 << NUM_CTR) - 32'h1);

   // R1 and R2: fixed fields of the control register
   a_r2_ctrl_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
      addr_i == A_CTRL |-> (rdata_o[15:11] == 5'(NUM_CTR) && rdata_o[6] && rdata_o[2:1] == 2'b00));

   // R3: a set write leaves every legal written bit set
   a_r3_en_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == A_EN_SET) |=> ((en_q & $past(wdata_i) & IMPL) == ($past(wdata_i) & IMPL)));

   // R4: unimplemented mask bits stay clear
   a_r4_unimpl_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((en_q | ie_q) & ~IMPL) == 32'h0);

   // R12: the interrupt only drops on a status clear or an enable clear
   a_r12_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && !(we_i && (addr_i == A_OVF || addr_i == A_IE_CLR))) |=> irq_o);

   // R7: the cycle counter holds while counting is off
   a_r7_cycle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !(we_i && (addr_i == A_CYC || addr_i == A_CTRL))) |=> $stable(cyc_q));
endmodule

bind pmc_bank pmc_bank_chk #(.NUM_CTR(NUM_CTR)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .we_i    (we_i),
   .addr_i  (addr_i),
   .wdata_i (wdata_i),
   .rdata_o (rdata_o),
   .irq_o   (irq_o),
   .en_q    (en_q),
   .ie_q    (ie_q),
   .run_q   (run_q),
   .cyc_q   (cyc_q)
);

// File: tb/sim_pmc_bank.sv
module sim_pmc_bank;
   localparam int N = 4;
   localparam int NE = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NE-1:0] evt = '0;
   logic [1:0]  priv = 2'd1;
   logic        irq;
   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pmc_bank #(.NUM_CTR(N), .NUM_EVT(NE)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .evt_i(evt), .priv_i(priv), .irq_o(irq));

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); we = 1'b1; addr = a; wdata = d;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); addr = a; #1; d = rdata;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic pulse(input logic [NE-1:0] m, input int n);
      @(negedge clk); evt = m;
      repeat (n) @(negedge clk);
      evt = '0;
   endtask

   function automatic bit will_count(input logic [31:0] ty, input bit en,
                                     input logic [NE-1:0] ev, input logic [1:0] pv);
      bit ex;
      ex = (pv == 2'd0 && ty[30]) || (pv == 2'd1 && ty[31]);
      return en && (ty[15:0] < 16'(NE)) && ev[ty[4:0]] && !ex;
   endfunction

   initial begin
      #(10 * 200000);
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, c0;
      logic [31:0] ty [N];
      logic [31:0] ex [N];
      logic [31:0] enr;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R13 reset state
      chk_rd("R13 ctrl", 8'h00, 32'h2040);
      chk_rd("R13 enable", 8'h01, 32'h0);
      chk_rd("R13 ovf", 8'h03, 32'h0);
      chk_rd("R13 ie", 8'h05, 32'h0);
      chk_rd("R13 type0", 8'h80, 32'h0);
      chk_rd("R13 cnt3", 8'h43, 32'h0);
      chk("R12 irq after reset", 32'(irq), 32'h0);

      // R1 / R2 control register
      wr(8'h00, 32'h0000_003E);
      chk_rd("R1 ctrl rw bits", 8'h00, 32'h2078);
      wr(8'h00, 32'h0000_0046);
      chk_rd("R2 ctrl after reset write", 8'h00, 32'h2040);

      // R3 / R4 enable pair
      wr(8'h01, 32'h7FFF_FFFF);
      chk_rd("R4 enable set impl only", 8'h01, 32'hF);
      chk_rd("R3 enable clr reads mask", 8'h02, 32'hF);
      wr(8'h02, 32'hFFFF_FFFC);
      chk_rd("R3 enable after clear", 8'h01, 32'h3);
      chk_rd("R3 clr view after clear", 8'h02, 32'h3);

      // R5 interrupt enable pair
      wr(8'h05, 32'hFFFF_FFFF);
      chk_rd("R5 ie all cleared", 8'h04, 32'h0);
      wr(8'h04, 32'h7FFF_FFFF);
      chk_rd("R5 ie set impl only", 8'h05, 32'hF);

      // R8 type register fields
      wr(8'h82, 32'hFFFF_FFFF);
      chk_rd("R8 type keep bits", 8'h82, 32'hFF00_FFFF);

      // R9 indirect access
      wr(8'h06, 32'd1);
      wr(8'h07, 32'h0000_00EA);
      chk_rd("R9 indirect type alias", 8'h81, 32'hEA);
      wr(8'h08, 32'hDEAD_BEEF);
      chk_rd("R9 indirect count alias", 8'h41, 32'hDEAD_BEEF);
      wr(8'h42, 32'h1234_5678);
      wr(8'h06, 32'd2);
      chk_rd("R9 indirect count read", 8'h08, 32'h1234_5678);
      wr(8'h06, 32'd7);
      wr(8'h08, 32'h5555_5555);
      wr(8'h07, 32'h0000_0013);
      chk_rd("R9 out of range read", 8'h08, 32'h0);
      chk_rd("R9 out of range no write c1", 8'h41, 32'hDEAD_BEEF);
      chk_rd("R9 out of range no write c2", 8'h42, 32'h1234_5678);
      chk_rd("R9 out of range no type write", 8'h81, 32'hEA);

      // R10 unsupported event value readback
      wr(8'h80, 32'h0000_003F);
      wr(8'h40, 32'h0000_003F);
      chk_rd("R10 unsupported readback", 8'h40, 32'h3F);

      // R6 overflow on two counters, R12 interrupt
      wr(8'h80, 32'h0000_0011);
      wr(8'h81, 32'h0000_0013);
      wr(8'h40, 32'hFFFF_FFF0);
      wr(8'h41, 32'hFFFF_FFFA);
      wr(8'h03, 32'hFFFF_FFFF);
      wr(8'h00, 32'h1);
      pulse((NE'(1) << 8'h11) | (NE'(1) << 8'h13), 20);
      wr(8'h00, 32'h0);
      chk_rd("R6 ovf both", 8'h03, 32'h3);
      chk_rd("R6 cnt0 after wrap", 8'h40, 32'h4);
      chk_rd("R6 cnt1 after wrap", 8'h41, 32'hE);
      chk("R12 irq high", 32'(irq), 32'h1);
      wr(8'h03, 32'h1);
      chk_rd("R6 w1c bit0", 8'h03, 32'h2);
      chk("R12 irq still high", 32'(irq), 32'h1);
      wr(8'h05, 32'h2);
      chk("R12 irq masked", 32'(irq), 32'h0);
      wr(8'h03, 32'h2);
      chk_rd("R6 w1c bit1", 8'h03, 32'h0);

      // R7 no counting with global enable off
      pulse(NE'(1) << 8'h11, 5);
      chk_rd("R7 global off", 8'h40, 32'h4);

      // R11 same event on two counters
      wr(8'h80, 32'h0000_0013);
      wr(8'h00, 32'h3);
      pulse(NE'(1) << 8'h13, 9);
      wr(8'h00, 32'h0);
      chk_rd("R11 cnt0", 8'h40, 32'd9);
      chk_rd("R11 cnt1", 8'h41, 32'd9);

      // R8 privilege exclusion
      wr(8'h80, 32'h4000_0013);
      wr(8'h81, 32'h8000_0013);
      wr(8'h00, 32'h3);
      priv = 2'd0;
      pulse(NE'(1) << 8'h13, 4);
      priv = 2'd1;
      pulse(NE'(1) << 8'h13, 3);
      wr(8'h00, 32'h0);
      chk_rd("R8 exclude level0", 8'h40, 32'd3);
      chk_rd("R8 exclude level1", 8'h41, 32'd4);

      // R10 write wins over increment
      wr(8'h80, 32'h0000_0011);
      wr(8'h00, 32'h1);
      @(negedge clk); evt = NE'(1) << 8'h11;
      wr(8'h40, 32'h0000_0100);
      evt = '0;
      wr(8'h00, 32'h0);
      chk_rd("R10 write beats increment", 8'h40, 32'h100);

      // R6 cycle counter wrap into bit 31
      wr(8'h09, 32'hFFFF_FFF0);
      wr(8'h01, 32'h8000_0000);
      wr(8'h03, 32'hFFFF_FFFF);
      wr(8'h00, 32'h1);
      repeat (20) @(negedge clk);
      wr(8'h00, 32'h0);
      rd(8'h03, d);
      chk("R6 cycle wrap bit31", d & 32'h8000_0000, 32'h8000_0000);

      // R2 counter reset bits
      rd(8'h09, c0);
      wr(8'h00, 32'h2);
      chk_rd("R2 event reset cnt0", 8'h40, 32'h0);
      chk_rd("R2 event reset cnt1", 8'h41, 32'h0);
      chk_rd("R2 cycle kept", 8'h09, c0);
      wr(8'h00, 32'h4);
      chk_rd("R2 cycle reset", 8'h09, 32'h0);

      // R7 constrained random counting against a model
      wr(8'h02, 32'hFFFF_FFFF);
      enr = $urandom & 32'hF;
      wr(8'h01, enr);
      for (int k = 0; k < N; k++) begin
         ty[k] = {2'($urandom), 14'b0, 16'($urandom % 40)};
         wr(8'h80 + 8'(k), ty[k]);
         ex[k] = '0;
      end
      wr(8'h00, 32'h3);
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         evt = NE'($urandom);
         priv = 2'($urandom);
         for (int k = 0; k < N; k++)
            if (will_count(ty[k], enr[k], evt, priv)) ex[k]++;
      end
      @(negedge clk); evt = '0;
      wr(8'h00, 32'h0);
      for (int k = 0; k < N; k++) begin
         rd(8'h40 + 8'(k), d);
         chk($sformatf("R7 random cnt%0d", k), d, ex[k]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule